// File: doc/BRIEF.md
# Crypto Service Request Controller

This block is the fabric-side sequencer for a block-cipher service that lives behind a byte-wide message channel. On a start request it fills a 44-byte parameter record and a 16-byte source block in a shared byte memory. It then transmits a one-byte service command followed by the record's address, four bytes, lowest byte first. Next it waits for the receive-okay indication from the channel and takes in a six-byte reply. The reply must echo the command and carry a zero status. Only then does the block fetch the 16-byte output block from the destination buffer.

The controller runs a fixed demonstration pattern. Successive operations alternate between two kinds. The first kind encrypts a 128-bit counter, which advances after each successful encryption. The second kind decrypts the most recent ciphertext, which should return that counter value. Every failure ends the operation with a flag that stays visible until the next start. The failure cases are a wrong echoed command, a non-zero service status, and a response that never arrives within a programmable number of cycles.

Top module: `crypto_svc_ctrl`

## Requirements
- R1: The parameter record is written at DESC_BASE with this layout. Bytes 0-15 hold the key and bytes 16-31 hold the IV, byte i taken from bits [8i+7:8i] of the input. Bytes 32-33 hold a block count of 1 in little-endian order. Byte 34 is the mode byte: bit 7 is set for decryption and bits 1:0 carry the cipher mode. Byte 35 is 0. Bytes 36-39 hold DST_BASE and bytes 40-43 hold SRC_BASE, each as a 32-bit little-endian value.
- R2: The 16-byte source block is written at SRC_BASE, byte 0 first. An encryption takes the counter in big-endian order, so byte 0 is counter bits [127:120]. A decryption takes the last ciphertext, byte 0 from bits [127:120].
- R3: The command byte goes out first, 3 when key_sel is 0 and 6 when it is 1. Then come the four bytes of DESC_BASE, least significant first. tx_data holds steady while tx_valid is high and tx_ready is low.
- R4: rx_ready is raised only after rx_ok has been seen, and exactly six reply bytes are consumed: the command, the status, and four pointer bytes.
- R5: On success the 16 bytes read from DST_BASE appear on result with byte 0 in bits [127:120]. done pulses for one cycle, status_code is 0 and all error flags are clear.
- R6: A non-zero status ends the operation without any read of the destination buffer. The status is placed on status_code and classified on fault_kind: 1 for 127 (bus error), 2 for 253 (not licensed), 3 for 254 (factory disabled), 4 for 255 (user disabled), 5 for any other value. Both stay unchanged until the next accepted start.
- R7: An echoed command that differs from the one sent raises cmd_mismatch, even when the status is 0, and the destination buffer is not read.
- R8: While waiting for rx_ok, the block counts cycles. The wait ends with timed_out set once the count reaches timeout_cycles with rx_ok still low, and rx_ok is checked before the limit, so a limit of 0 still accepts a response already present. At most one error indication is active at a time.
- R9: After reset the first operation encrypts, and operations then alternate. The phase and the counter advance only on success. did_decrypt reports the kind of the operation that just finished, and result changes only on success.
- R10: After reset busy, done, result, status_code, fault_kind, cmd_mismatch and timed_out are all 0.
- R11: start is ignored while busy, and the configuration latched at the accepted start is used for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| key_sel | input | 1 | 0: 128-bit key service, 1: 256-bit key service |
| opmode | input | 2 | Cipher mode field copied into the mode byte |
| key_in | input | 128 | Key bytes, byte i in bits [8i+7:8i] |
| iv_in | input | 128 | IV bytes, byte i in bits [8i+7:8i] |
| timeout_cycles | input | TMO_W | Response wait limit in cycles |
| tx_valid | output | 1 | Command byte valid |
| tx_data | output | 8 | Command stream byte |
| tx_ready | input | 1 | Channel accepts the byte |
| rx_ok | input | 1 | Receive-okay: a reply is available |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte |
| rx_ready | output | 1 | Controller takes the reply byte |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| result | output | 128 | Last successful output block |
| did_decrypt | output | 1 | Kind of the operation that just ended |
| status_code | output | 8 | Non-zero service status of the last operation |
| fault_kind | output | 3 | Classified status |
| cmd_mismatch | output | 1 | Echoed command was wrong |
| timed_out | output | 1 | Response wait expired |

## Verification
The assertions assume a well-behaved channel. Once rx_ok rises, it stays high until all six reply bytes have been taken. The memory returns read data exactly one cycle after a read. The bench's service model meets both rules: it raises rx_ok only together with a complete queued reply and drops it after the last byte. Operations that exercise the timeout never answer at all, so no late reply can cross into the next operation.

// File: rtl/crsc_pkg.sv
// Shared constants and types for the crypto service request controller.
// Assumes a single-block request and byte-wide channel and memory.
package crsc_pkg;

    localparam int DESC_LEN  = 44;
    localparam int BLK_BYTES = 16;
    localparam int RESP_LEN  = 6;

    localparam logic [7:0] CMD_KEY128 = 8'd3;
    localparam logic [7:0] CMD_KEY256 = 8'd6;

    localparam logic [7:0] STS_BUS     = 8'd127;
    localparam logic [7:0] STS_NOLIC   = 8'd253;
    localparam logic [7:0] STS_FACTORY = 8'd254;
    localparam logic [7:0] STS_USER    = 8'd255;

    typedef enum logic [2:0] {
        FK_NONE    = 3'd0,
        FK_BUS     = 3'd1,
        FK_NOLIC   = 3'd2,
        FK_FACTORY = 3'd3,
        FK_USER    = 3'd4,
        FK_OTHER   = 3'd5
    } fault_t;

    typedef enum logic [3:0] {
        S_IDLE, S_DESC, S_SRC, S_TX, S_WAIT, S_RX, S_CHECK, S_READ, S_FIN
    } state_t;

endpackage

// File: rtl/crsc_desc_byte.sv
// Combinational parameter-record byte generator.
// Returns the byte at offset idx (0..43) of the request record.
// Assumes idx stays in range; out-of-range offsets return zero.
module crsc_desc_byte (
    input  logic [5:0]   idx,
    input  logic [127:0] key,
    input  logic [127:0] iv,
    input  logic         decrypt,
    input  logic [1:0]   opmode,
    input  logic [31:0]  dst_ptr,
    input  logic [31:0]  src_ptr,
    output logic [7:0]   byte_o
);

    // Select the field that covers this offset.
    always_comb begin
        byte_o = 8'h00;
        if (idx < 6'd16)
            byte_o = key[{idx[3:0], 3'b000} +: 8];
        else if (idx < 6'd32)
            byte_o = iv[{idx[3:0], 3'b000} +: 8];
        else if (idx == 6'd32)
            byte_o = 8'h01;
        else if (idx == 6'd34)
            byte_o = {decrypt, 5'b00000, opmode};
        else if (idx >= 6'd36 && idx < 6'd40)
            byte_o = dst_ptr[{idx[1:0], 3'b000} +: 8];
        else if (idx >= 6'd40 && idx < 6'd44)
            byte_o = src_ptr[{idx[1:0], 3'b000} +: 8];
    end

endmodule

// File: rtl/crsc_wait_timer.sv
// Response-wait cycle counter.
// Counts cycles while run is high and flags when the count reaches limit.
// Assumes run drops between waits so each wait starts from zero.
module crsc_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             hit
);

    logic [TMO_W-1:0] count;

    // Advance while waiting, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            count <= '0;
        else if (count != {TMO_W{1'b1}})
            count <= count + 1'b1;
    end

    assign hit = run && (count >= limit);

endmodule

// File: rtl/crsc_resp_check.sv
// Reply collector: captures the echoed command and status of a six-byte
// reply and classifies the status. Assumes the caller stops taking bytes
// after last_take.
module crsc_resp_check
    import crsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic [7:0] rx_byte,
    input  logic [7:0] exp_cmd,
    output logic       last_take,
    output logic       echo_ok,
    output logic [7:0] status,
    output fault_t     fault
);

    logic [2:0] cnt;
    logic [7:0] cmd_r;

    // Count reply bytes and capture the command and status ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            cmd_r  <= '0;
            status <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= cnt + 1'b1;
            if (cnt == 3'd0) cmd_r  <= rx_byte;
            if (cnt == 3'd1) status <= rx_byte;
        end
    end

    assign last_take = take && (cnt == 3'(RESP_LEN - 1));
    assign echo_ok   = (cmd_r == exp_cmd);

    // Map the raw status to a fault class.
    always_comb begin
        case (status)
            8'd0:        fault = FK_NONE;
            STS_BUS:     fault = FK_BUS;
            STS_NOLIC:   fault = FK_NOLIC;
            STS_FACTORY: fault = FK_FACTORY;
            STS_USER:    fault = FK_USER;
            default:     fault = FK_OTHER;
        endcase
    end

    AST_RESP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cnt < 3'(RESP_LEN)); // R4

endmodule

// File: rtl/crypto_svc_ctrl.sv
// Crypto service request controller (top).
// Writes the request record and source block to byte memory, sends the
// command and record pointer, waits for the reply, checks it, and reads
// the output block. Alternates counter encryption with decryption of the
// latest ciphertext. Assumes rx_ok stays high until the reply is drained
// and memory read data arrives one cycle after the read.
module crypto_svc_ctrl
    import crsc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DESC_BASE = 0,
    parameter int SRC_BASE  = 64,
    parameter int DST_BASE  = 128,
    parameter int TMO_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              key_sel,
    input  logic [1:0]        opmode,
    input  logic [127:0]      key_in,
    input  logic [127:0]      iv_in,
    input  logic [TMO_W-1:0]  timeout_cycles,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_ok,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [127:0]      result,
    output logic              did_decrypt,
    output logic [7:0]        status_code,
    output logic [2:0]        fault_kind,
    output logic              cmd_mismatch,
    output logic              timed_out
);

    localparam logic [ADDR_W-1:0] DESC_A   = ADDR_W'(DESC_BASE);
    localparam logic [ADDR_W-1:0] SRC_A    = ADDR_W'(SRC_BASE);
    localparam logic [ADDR_W-1:0] DST_A    = ADDR_W'(DST_BASE);
    localparam logic [31:0]       DESC_PTR = 32'(DESC_BASE);
    localparam logic [5:0]        DESC_LAST = 6'(DESC_LEN - 1);
    localparam logic [5:0]        BLK_LAST  = 6'(BLK_BYTES - 1);

    state_t       state;
    logic [5:0]   idx;
    logic         ks_q, phase_dec, run_ok;
    logic [1:0]   om_q;
    logic [127:0] key_q, iv_q, ctr, last_ct, res_buf;
    logic [7:0]   cmd_q, desc_b, src_b, resp_status;
    logic [127:0] src_blk;
    logic         tmo_hit, last_take, echo_ok, accept;
    fault_t       resp_fault;

    assign accept  = (state == S_IDLE) && start;
    assign busy    = (state != S_IDLE);
    assign cmd_q   = ks_q ? CMD_KEY256 : CMD_KEY128;
    assign src_blk = phase_dec ? last_ct : ctr;
    assign src_b   = src_blk[{4'd15 - idx[3:0], 3'b000} +: 8];

    crsc_desc_byte u_desc (
        .idx     (idx),
        .key     (key_q),
        .iv      (iv_q),
        .decrypt (phase_dec),
        .opmode  (om_q),
        .dst_ptr (32'(DST_BASE)),
        .src_ptr (32'(SRC_BASE)),
        .byte_o  (desc_b)
    );

    crsc_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_WAIT),
        .limit (timeout_cycles),
        .hit   (tmo_hit)
    );

    crsc_resp_check u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .take      (rx_valid && rx_ready),
        .rx_byte   (rx_data),
        .exp_cmd   (cmd_q),
        .last_take (last_take),
        .echo_ok   (echo_ok),
        .status    (resp_status),
        .fault     (resp_fault)
    );

    // Drive the channel and memory strobes from the current state.
    always_comb begin
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        rx_ready  = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = 8'h00;
        case (state)
            S_DESC: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = DESC_A + ADDR_W'(idx);
                mem_wdata = desc_b;
            end
            S_SRC: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = SRC_A + ADDR_W'(idx);
                mem_wdata = src_b;
            end
            S_TX: begin
                tx_valid = 1'b1;
                tx_data  = (idx == 6'd0) ? cmd_q
                                         : DESC_PTR[{idx[1:0] - 2'd1, 3'b000} +: 8];
            end
            S_RX:   rx_ready = 1'b1;
            S_READ: begin
                mem_en   = ~idx[4];
                mem_addr = DST_A + ADDR_W'(idx);
            end
            default: ;
        endcase
    end

    // Sequence one request and hold its outcome until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            idx          <= '0;
            ks_q         <= 1'b0;
            om_q         <= '0;
            key_q        <= '0;
            iv_q         <= '0;
            phase_dec    <= 1'b0;
            run_ok       <= 1'b0;
            ctr          <= '0;
            last_ct      <= '0;
            res_buf      <= '0;
            done         <= 1'b0;
            result       <= '0;
            did_decrypt  <= 1'b0;
            status_code  <= '0;
            fault_kind   <= '0;
            cmd_mismatch <= 1'b0;
            timed_out    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    ks_q         <= key_sel;
                    om_q         <= opmode;
                    key_q        <= key_in;
                    iv_q         <= iv_in;
                    run_ok       <= 1'b0;
                    status_code  <= '0;
                    fault_kind   <= '0;
                    cmd_mismatch <= 1'b0;
                    timed_out    <= 1'b0;
                    idx          <= '0;
                    state        <= S_DESC;
                end
                S_DESC: begin
                    idx   <= (idx == DESC_LAST) ? 6'd0 : idx + 6'd1;
                    state <= (idx == DESC_LAST) ? S_SRC : S_DESC;
                end
                S_SRC: begin
                    idx   <= (idx == BLK_LAST) ? 6'd0 : idx + 6'd1;
                    state <= (idx == BLK_LAST) ? S_TX : S_SRC;
                end
                S_TX: if (tx_ready) begin
                    idx   <= (idx == 6'd4) ? 6'd0 : idx + 6'd1;
                    state <= (idx == 6'd4) ? S_WAIT : S_TX;
                end
                S_WAIT: begin
                    if (rx_ok) begin
                        state <= S_RX;
                    end else if (tmo_hit) begin
                        timed_out <= 1'b1;
                        state     <= S_FIN;
                    end
                end
                S_RX: if (last_take) state <= S_CHECK;
                S_CHECK: begin
                    if (!echo_ok) begin
                        cmd_mismatch <= 1'b1;
                        state        <= S_FIN;
                    end else if (resp_status != 8'd0) begin
                        status_code <= resp_status;
                        fault_kind  <= resp_fault;
                        state       <= S_FIN;
                    end else begin
                        idx   <= '0;
                        state <= S_READ;
                    end
                end
                S_READ: begin
                    if (idx != 6'd0) res_buf <= {res_buf[119:0], mem_rdata};
                    if (idx == 6'(BLK_BYTES)) begin
                        run_ok <= 1'b1;
                        state  <= S_FIN;
                    end else begin
                        idx <= idx + 6'd1;
                    end
                end
                S_FIN: begin
                    done        <= 1'b1;
                    did_decrypt <= phase_dec;
                    state       <= S_IDLE;
                    if (run_ok) begin
                        result    <= res_buf;
                        phase_dec <= ~phase_dec;
                        if (!phase_dec) begin
                            ctr     <= ctr + 128'd1;
                            last_ct <= res_buf;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_RX_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rx_ok); // R4
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({timed_out, cmd_mismatch, status_code != 8'd0})); // R8
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(status_code) && $stable(fault_kind)); // R6
    AST_NO_READ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_mismatch || status_code != 8'd0 || timed_out) |-> !(mem_en && !mem_we)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en && !tx_valid && !rx_ready); // R11

endmodule

// File: tb/tb_crypto_svc_ctrl.sv
module tb_crypto_svc_ctrl;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, key_sel = 1'b0;
    logic [1:0] opmode = 2'd0;
    logic [127:0] key_in = '0, iv_in = '0;
    logic [15:0] timeout_cycles = 16'd100;
    logic tx_valid, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic rx_ok = 1'b0, rx_valid = 1'b0, rx_ready;
    logic [7:0] rx_data = 8'h00;
    logic mem_en, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic busy, done, did_decrypt, cmd_mismatch, timed_out;
    logic [127:0] result;
    logic [7:0] status_code;
    logic [2:0] fault_kind;

    always #(CLK_P/2) clk = ~clk;

    crypto_svc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .key_sel(key_sel), .opmode(opmode),
        .key_in(key_in), .iv_in(iv_in), .timeout_cycles(timeout_cycles),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_ok(rx_ok), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result),
        .did_decrypt(did_decrypt), .status_code(status_code), .fault_kind(fault_kind),
        .cmd_mismatch(cmd_mismatch), .timed_out(timed_out)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] mem [0:255];
    logic [7:0] eng_buf [0:15];

    // Memory model; the destination window returns the engine output.
    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we)
            mem_rdata <= (mem_addr >= 8'd128 && mem_addr < 8'd144) ? eng_buf[mem_addr[3:0]] : mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] f_out(input logic [127:0] src, input logic [127:0] key);
        logic [127:0] r;
        for (int j = 0; j < 16; j++) r[127-8*j -: 8] = src[127-8*j -: 8] ^ key[8*j +: 8] ^ 8'h5A;
        return r;
    endfunction

    function automatic logic [2:0] f_kind(input logic [7:0] s);
        case (s)
            8'd127: return 3'd1;
            8'd253: return 3'd2;
            8'd254: return 3'd3;
            8'd255: return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    // Service model controls and observations
    int eng_delay = 0;
    bit eng_silent = 0, eng_badcmd = 0;
    logic [7:0] eng_status = 8'd0;
    logic [7:0] txb [0:4];
    int cmds_seen = 0, dst_reads = 0, gate_viol = 0;
    logic exp_dec;
    logic [127:0] exp_src;
    logic [1:0] exp_om;

    // Service model: collects the command, checks memory, replies.
    initial begin
        int st = 0, n = 0, w = 0, ri = 0;
        bit take_pend = 0;
        logic [7:0] resp [0:5];
        forever begin
            @(negedge clk);
            if (mem_en && !mem_we && mem_addr >= 8'd128) dst_reads++;
            if (rx_ready && !rx_ok) gate_viol++;
            case (st)
                0: begin
                    tx_ready = ($urandom % 4) != 0;
                    if (tx_valid && tx_ready) begin
                        txb[n] = tx_data; n++;
                        if (n == 5) begin st = 1; w = eng_delay; cmds_seen++; end
                    end
                end
                1: begin
                    tx_ready = 1'b0;
                    if (eng_silent) begin st = 0; n = 0; end
                    else if (w > 0) w--;
                    else begin
                        bit ok1 = 1, ok2 = 1;
                        logic [127:0] sm;
                        for (int i = 0; i < 16; i++) begin
                            if (mem[i] !== key_in[8*i +: 8]) ok1 = 0;
                            if (mem[16+i] !== iv_in[8*i +: 8]) ok1 = 0;
                            sm[127-8*i -: 8] = mem[64+i];
                        end
                        if (mem[32] !== 8'h01 || mem[33] !== 8'h00 || mem[35] !== 8'h00) ok1 = 0;
                        if (mem[34] !== {exp_dec, 5'b0, exp_om}) ok1 = 0;
                        if ({mem[39], mem[38], mem[37], mem[36]} !== 32'd128) ok1 = 0;
                        if ({mem[43], mem[42], mem[41], mem[40]} !== 32'd64) ok1 = 0;
                        chk(ok1, "R1 record layout", {120'd0, mem[34]}, {120'd0, exp_dec, 5'b0, exp_om});
                        ok2 = (sm === exp_src);
                        chk(ok2, "R2 source block", sm, exp_src);
                        for (int j = 0; j < 16; j++) eng_buf[j] = mem[64+j] ^ mem[j] ^ 8'h5A;
                        resp[0] = eng_badcmd ? (txb[0] ^ 8'h01) : txb[0];
                        resp[1] = eng_status;
                        resp[2] = txb[1]; resp[3] = txb[2]; resp[4] = txb[3]; resp[5] = txb[4];
                        ri = 0; rx_ok = 1'b1; rx_valid = 1'b1; rx_data = resp[0];
                        take_pend = 0; st = 2;
                    end
                end
                default: begin
                    if (take_pend) begin
                        ri++;
                        if (ri == 6) begin
                            rx_ok = 1'b0; rx_valid = 1'b0; st = 0; n = 0;
                        end else rx_data = resp[ri];
                    end
                    take_pend = (st == 2) && rx_valid && rx_ready;
                end
            endcase
        end
    end

    // Bench model of the alternating pattern
    logic [127:0] ctr_m = '0, last_m = '0;
    logic dec_m = 1'b0;

    // fault: 0 none, 1 status, 2 echo mismatch, 3 silent
    task automatic run_op(input logic ks, input logic [1:0] om, input int fault,
                          input logic [7:0] fst, input int dly, input logic [15:0] tmo, input bit poke);
        logic [127:0] prev_res, exp_res;
        int c0, w;
        key_in = {$urandom, $urandom, $urandom, $urandom};
        iv_in  = {$urandom, $urandom, $urandom, $urandom};
        key_sel = ks; opmode = om; timeout_cycles = tmo;
        eng_delay = dly; eng_silent = (fault == 3); eng_badcmd = (fault == 2);
        eng_status = (fault == 1) ? fst : 8'd0;
        exp_dec = dec_m; exp_om = om;
        exp_src = dec_m ? last_m : ctr_m;
        exp_res = f_out(exp_src, key_in);
        prev_res = result;
        dst_reads = 0; gate_viol = 0; c0 = cmds_seen;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1; key_sel = ~ks;
            @(negedge clk); start = 1'b0; key_sel = ks;
        end
        w = 0;
        while (!done && w < 3000) begin @(negedge clk); w++; end
        chk(done === 1'b1, "R5 done pulse", {127'd0, done}, 128'd1);
        chk(txb[0] === (ks ? 8'd6 : 8'd3) && {txb[4], txb[3], txb[2], txb[1]} === 32'd0,
            "R3 command and pointer", {88'd0, txb[0], txb[4], txb[3], txb[2], txb[1]},
            {88'd0, (ks ? 8'd6 : 8'd3), 32'd0});
        chk(gate_viol == 0, "R4 reply gated by rx_ok", 128'(gate_viol), 128'd0);
        case (fault)
            0: begin
                chk(result === exp_res, "R5 result block", result, exp_res);
                chk(status_code === 8'd0 && !cmd_mismatch && !timed_out, "R5 clean status",
                    {120'd0, status_code}, 128'd0);
                chk(did_decrypt === dec_m, "R9 alternation", {127'd0, did_decrypt}, {127'd0, dec_m});
                if (!dec_m) begin last_m = exp_res; ctr_m = ctr_m + 128'd1; end
                dec_m = ~dec_m;
            end
            1: begin
                chk(status_code === fst, "R6 status code", {120'd0, status_code}, {120'd0, fst});
                chk(fault_kind === f_kind(fst), "R6 fault class", {125'd0, fault_kind}, {125'd0, f_kind(fst)});
                chk(dst_reads == 0, "R6 no buffer read", 128'(dst_reads), 128'd0);
                chk(result === prev_res, "R9 result kept on fault", result, prev_res);
            end
            2: begin
                chk(cmd_mismatch === 1'b1 && status_code === 8'd0, "R7 echo mismatch",
                    {127'd0, cmd_mismatch}, 128'd1);
                chk(dst_reads == 0, "R7 no buffer read", 128'(dst_reads), 128'd0);
            end
            default: begin
                chk(timed_out === 1'b1 && !cmd_mismatch, "R8 timeout flag", {127'd0, timed_out}, 128'd1);
                chk(result === prev_res, "R9 result kept on timeout", result, prev_res);
            end
        endcase
        repeat (4) @(negedge clk);
        if (fault == 1)
            chk(status_code === fst, "R6 status held", {120'd0, status_code}, {120'd0, fst});
        if (poke) begin
            repeat (100) @(negedge clk);
            chk(busy === 1'b0 && cmds_seen == c0 + 1, "R11 start ignored while busy",
                128'(cmds_seen - c0), 128'd1);
        end
    endtask

    initial begin
        #(CLK_P * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=expired exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && result === '0 && status_code === 8'd0 && fault_kind === 3'd0
            && !cmd_mismatch && !timed_out, "R10 reset state", result, 128'd0);
        // Directed cases
        run_op(1'b0, 2'd0, 0, 8'd0, 2, 16'd100, 1'b0);   // encrypt counter 0
        run_op(1'b1, 2'd1, 0, 8'd0, 0, 16'd0, 1'b0);     // decrypt, limit 0 with immediate reply (R8)
        run_op(1'b0, 2'd2, 1, 8'd127, 3, 16'd100, 1'b0);
        run_op(1'b0, 2'd3, 1, 8'd253, 1, 16'd100, 1'b0);
        run_op(1'b1, 2'd0, 1, 8'd254, 0, 16'd100, 1'b0);
        run_op(1'b0, 2'd1, 1, 8'd255, 4, 16'd100, 1'b0);
        run_op(1'b0, 2'd1, 1, 8'd9, 2, 16'd100, 1'b0);
        run_op(1'b1, 2'd2, 2, 8'd0, 1, 16'd100, 1'b0);
        run_op(1'b0, 2'd0, 3, 8'd0, 0, 16'd20, 1'b0);
        run_op(1'b1, 2'd3, 0, 8'd0, 5, 16'd6, 1'b1);     // R11 poke, reply just inside limit
        // Random mix
        for (int k = 0; k < 24; k++) begin
            int r = $urandom % 8;
            logic [7:0] sv;
            case ($urandom % 5)
                0: sv = 8'd127; 1: sv = 8'd253; 2: sv = 8'd254; 3: sv = 8'd255;
                default: sv = 8'($urandom % 126 + 1);
            endcase
            run_op(1'($urandom), 2'($urandom), (r < 5) ? 0 : r - 4, sv,
                   int'($urandom % 8), (r == 7) ? 16'd15 : 16'd100, 1'b0);
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule